// File: doc/BRIEF.md
# Cache Test Register Access Port

This block gives test and debug software a way into the tag, line-state and replacement arrays of a 4-way set-associative on-chip cache with 128 sets and 16-byte lines. It presents three 32-bit registers behind a small write/read port: a data register, a status register and a control register. A write to the control register starts one of four operations:
- a line-buffer access,
- a direct write of one cache way,
- a look-up read of one set and way,
- a flush of every set.

The block keeps the tags, the line contents written through it, a 2-bit line state per way, three tree pseudo-LRU bits per set, a 128-bit fill buffer and a 128-bit read buffer. A strap sampled while reset is held selects write-back or write-through behaviour. In write-back mode a cache write takes its line state from a control field, and an extension bit turns the status register into a per-way state view. In write-through mode the status valid bit alone decides whether a written way becomes valid.

Top module: `cache_test_port`

## Requirements
- R1: After a synchronous reset the data, status and control registers all read 0 and every way is invalid with its set's LRU bits at 0. Register select codes are 0 data, 1 status, 2 control; select 3 always reads 0. A read presents the register on `rd_data` one clock after `rd_sel` is applied.
- R2: Control bits 1:0 hold the operation code. 00 is a buffer access, 01 a cache write, 10 a cache read and 11 a flush. Bits 3:2 (entry) pick the way for cache operations and the doubleword for buffer accesses, and bits 10:4 pick the set. While the stored code is 00, a data register write fills doubleword `entry` of the fill buffer. A data register read always returns doubleword `entry` of the read buffer.
- R3: A cache write stores the status tag (bits 31:11) and the fill buffer into the chosen set and way. A later cache read of that set and way returns the tag in status bits 31:11 and loads the stored line into the read buffer.
- R4: With the strap low at reset (write-through), the extension bit (control 19) and the state field (control 18:17) cannot be written and read 0. A cache write makes the way exclusive (01) when status bit 10 is 1 and invalid (00) when it is 0.
- R5: With the strap high at reset (write-back), a cache write sets the way's state from control bits 18:17 and ignores status bit 10. States are encoded 00 invalid, 01 exclusive, 10 modified, 11 shared. The extension bit and the state field read back as written.
- R6: In write-back mode with the extension bit at 1, the status register shows the captured states of ways 3 down to 0 in bits 27:20, two bits per way with way 0 in 21:20. Bits 30:29 show the captured state of the way named by control 18:17. Bits 31, 28 and 19:11 read 0. With the extension bit at 0, bits 31:11 show the tag again.
- R7: A cache read captures the set's per-way valid bits into status 6:3 (way w at bit 3+w) and the accessed way's valid bit into status bit 10. A way counts as valid when its state is not 00.
- R8: A cache read captures the set's LRU bits into status 9:7 as {b2,b1,b0}. A cache write to way w sets b0 to the inverse of w[1]. It sets b1 (ways 0/1) or b2 (ways 2/3) to the inverse of w[0] and leaves the other pair bit unchanged.
- R9: Status register writes do not change status bits 9:3, and cannot change the tag while the extended view is shown.
- R10: A flush sets every way of every set to invalid and every LRU bit to 0.
- R11: The mode is the strap value on the last clock of reset; strap changes after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the mode strap is sampled while it is high |
| mode_strap | input | 1 | 1 selects write-back, 0 write-through |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written: 0 data, 1 status, 2 control |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Register read: 0 data, 1 status, 2 control, 3 none |
| rd_data | output | 32 | Registered read value, one clock after rd_sel |

## Verification
The bench attacks the pseudo-LRU path bits with writes to ways in both pairs. A design that flips the wrong pair bit, or clears the untouched one, shows a wrong status 9:7. It checks that write-back writes ignore status bit 10 and that write-through writes honour it. Swapping those sources leaves a way valid or invalid against expectation. It reads the extended view with a non-zero state selector to catch a reversed way order or a wrong selector. It also checks that a flush clears both state and LRU, and that a strap change after reset does not unlock the extension bit.

// File: rtl/cache_tr_pkg.sv
package cache_tr_pkg;
  localparam logic [1:0] OP_BUF   = 2'b00;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_FLUSH = 2'b11;

  localparam logic [1:0] ST_INV = 2'b00;
  localparam logic [1:0] ST_EXC = 2'b01;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int NWAYS = 4;

  // Tree update: b0 chooses the pair, b1 ways 0/1, b2 ways 2/3; point away from way.
  function automatic logic [2:0] plru_next(input logic [2:0] cur, input logic [1:0] way);
    logic [2:0] n;
    n    = cur;
    n[0] = ~way[1];
    if (way[1]) n[2] = ~way[0];
    else        n[1] = ~way[0];
    return n;
  endfunction
endpackage

// File: rtl/ctr_line_store.sv
module ctr_line_store #(
  parameter int SETS   = 128,
  parameter int TAG_W  = 21,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        way,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [LINE_W-1:0] line_in,
  output logic [TAG_W-1:0]  tag_out,
  output logic [LINE_W-1:0] line_out
);
  localparam int DEPTH = SETS * cache_tr_pkg::NWAYS;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [LINE_W-1:0] line_mem [DEPTH];
  logic [IDX_W+1:0]  addr;

  assign addr = {idx, way};

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[addr]  <= tag_in;
      line_mem[addr] <= line_in;
    end
  end

  assign tag_out  = tag_mem[addr];
  assign line_out = line_mem[addr];
endmodule

// File: rtl/ctr_state_store.sv
module ctr_state_store #(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       way,
  input  logic [1:0]       new_state,
  output logic [7:0]       set_states,
  output logic [2:0]       set_lru
);
  import cache_tr_pkg::*;

  logic [7:0] st_q  [SETS];
  logic [2:0] lru_q [SETS];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]  <= '0;
        lru_q[s] <= '0;
      end
    end else if (we) begin
      st_q[idx][{way, 1'b0} +: 2] <= new_state;
      lru_q[idx]                  <= plru_next(lru_q[idx], way);
    end
  end

  assign set_states = st_q[idx];
  assign set_lru    = lru_q[idx];
endmodule

// File: rtl/cache_test_port.sv
module cache_test_port #(
  parameter int SETS  = 128,
  parameter int TAG_W = 21
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_strap,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data
);
  import cache_tr_pkg::*;

  localparam int IDX_W   = $clog2(SETS);
  localparam int LINE_W  = NWAYS * 32;
  localparam int TAG_LSB = 32 - TAG_W;

  // stored registers
  logic             wb_mode;
  logic             ctl_ext;
  logic [1:0]       ctl_ss;
  logic [IDX_W-1:0] ctl_idx;
  logic [1:0]       ctl_ent;
  logic [1:0]       ctl_op;
  logic [TAG_W-1:0] st_tag;
  logic             st_v;
  logic [2:0]       st_lru;
  logic [3:0]       st_vld;
  logic [7:0]       st_ways;
  logic [3:0][31:0] fill_buf;
  logic [3:0][31:0] rd_buf;

  // write decode
  logic             ctl_we, stat_we, data_we;
  logic [1:0]       c_op, c_ent, c_ss, new_state;
  logic [IDX_W-1:0] c_idx;
  logic             do_wr, do_rd, do_fl, ext_view;

  assign ctl_we  = wr_en && (wr_sel == SEL_CTRL);
  assign stat_we = wr_en && (wr_sel == SEL_STAT);
  assign data_we = wr_en && (wr_sel == SEL_DATA);
  assign c_op    = wr_data[1:0];
  assign c_ent   = wr_data[3:2];
  assign c_idx   = wr_data[4 +: IDX_W];
  assign c_ss    = wr_data[18:17];
  assign do_wr   = ctl_we && (c_op == OP_WR);
  assign do_rd   = ctl_we && (c_op == OP_RD);
  assign do_fl   = ctl_we && (c_op == OP_FLUSH);
  assign ext_view  = wb_mode && ctl_ext;
  assign new_state = wb_mode ? c_ss : (st_v ? ST_EXC : ST_INV);

  logic [TAG_W-1:0]  tag_rd;
  logic [LINE_W-1:0] line_rd;
  logic [7:0]        set_states;
  logic [2:0]        set_lru;
  logic [3:0]        set_valid;

  ctr_line_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_lines (
    .clk(clk), .we(do_wr), .idx(c_idx), .way(c_ent),
    .tag_in(st_tag), .line_in(fill_buf),
    .tag_out(tag_rd), .line_out(line_rd)
  );

  ctr_state_store #(.SETS(SETS)) i_states (
    .clk(clk), .rst(rst), .flush(do_fl), .we(do_wr),
    .idx(c_idx), .way(c_ent), .new_state(new_state),
    .set_states(set_states), .set_lru(set_lru)
  );

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_valid
      assign set_valid[w] = |set_states[2*w +: 2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_mode  <= mode_strap;
      ctl_ext  <= 1'b0;
      ctl_ss   <= '0;
      ctl_idx  <= '0;
      ctl_ent  <= '0;
      ctl_op   <= '0;
      st_tag   <= '0;
      st_v     <= 1'b0;
      st_lru   <= '0;
      st_vld   <= '0;
      st_ways  <= '0;
      fill_buf <= '0;
      rd_buf   <= '0;
    end else begin
      if (ctl_we) begin
        ctl_op  <= c_op;
        ctl_ent <= c_ent;
        ctl_idx <= c_idx;
        ctl_ext <= wb_mode & wr_data[19];
        ctl_ss  <= wb_mode ? c_ss : 2'b00;
      end
      if (stat_we) begin
        if (!ext_view) st_tag <= wr_data[31:TAG_LSB];
        st_v <= wr_data[10];
      end
      if (data_we && (ctl_op == OP_BUF)) fill_buf[ctl_ent] <= wr_data;
      if (do_rd) begin
        st_tag  <= tag_rd;
        st_v    <= set_valid[c_ent];
        st_lru  <= set_lru;
        st_vld  <= set_valid;
        st_ways <= set_states;
        rd_buf  <= line_rd;
      end
    end
  end

  logic [31:0] ctl_view, stat_view, rd_next;

  always_comb begin
    ctl_view              = '0;
    ctl_view[19]          = ctl_ext;
    ctl_view[18:17]       = ctl_ss;
    ctl_view[4 +: IDX_W]  = ctl_idx;
    ctl_view[3:2]         = ctl_ent;
    ctl_view[1:0]         = ctl_op;

    stat_view             = '0;
    if (ext_view) begin
      stat_view[30:29]    = st_ways[{ctl_ss, 1'b0} +: 2];
      stat_view[27:20]    = st_ways;
    end else begin
      stat_view[31:TAG_LSB] = st_tag;
    end
    stat_view[10]         = st_v;
    stat_view[9:7]        = st_lru;
    stat_view[6:3]        = st_vld;

    case (rd_sel)
      SEL_DATA: rd_next = rd_buf[ctl_ent];
      SEL_STAT: rd_next = stat_view;
      SEL_CTRL: rd_next = ctl_view;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker (
  input logic        clk,
  input logic        rst,
  input logic        wb_mode,
  input logic        ctl_ext,
  input logic [1:0]  ctl_ss,
  input logic [1:0]  rd_sel,
  input logic [31:0] rd_data
);
  // R1
  reset_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 32'h0));

  // R1
  unused_select_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'd3) |=> (rd_data == 32'h0));

  // R11
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(wb_mode));

  // R4
  wt_locks_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_mode |-> (!ctl_ext && (ctl_ss == 2'b00)));

  // R4
  wt_ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!wb_mode && rd_sel == 2'd2) |=> (rd_data[19:17] == 3'b000));

  // R6
  ext_view_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_mode && ctl_ext && rd_sel == 2'd1) |=>
      (!rd_data[31] && !rd_data[28] && rd_data[19:11] == 9'h0));
endmodule

bind cache_test_port ctp_checker i_ctp_checker (
  .clk(clk), .rst(rst), .wb_mode(wb_mode), .ctl_ext(ctl_ext),
  .ctl_ss(ctl_ss), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_cache_test_port.sv
module test_cache_test_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_strap = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd3;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_test_port i_cache_test_port (
    .clk(clk), .rst(rst), .mode_strap(mode_strap), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
    rd_sel = 2'd3;
  endtask

  function automatic logic [31:0] ctl(input logic ext, input logic [1:0] ss,
                                      input int idx, input int ent, input logic [1:0] op);
    return {12'h0, ext, ss, 6'h0, idx[6:0], ent[1:0], op};
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; mode_strap = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mode_strap = ~strap;  // R11: late strap change must not matter
  endtask

  localparam logic [20:0] T1 = 21'h1A5C3;
  localparam logic [20:0] T2 = 21'h0F0F1;
  localparam logic [20:0] T3 = 21'h12345;

  task automatic t_reset;
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      rreg(s[1:0], v);
      check("R1 reset read", v, 32'h0);
    end
  endtask

  task automatic t_write_read_wb;
    logic [31:0] v;
    logic [31:0] dw [4];
    for (int k = 0; k < 4; k++) begin
      dw[k] = 32'hC0DE_0000 + 32'(k * 32'h1111);
      wreg(2'd2, ctl(1'b0, 2'b00, 0, k, 2'b00));
      wreg(2'd0, dw[k]);
    end
    wreg(2'd1, {T1, 1'b0, 10'h0});
    wreg(2'd2, ctl(1'b0, 2'b10, 5, 2, 2'b01));   // modified, way 2
    wreg(2'd2, ctl(1'b0, 2'b00, 5, 2, 2'b10));
    rreg(2'd1, v);
    // R3 tag, R7 valid way2 (bit5), R8 lru b2=1 b0=0, R5 bit10 ignored
    check("R3 R5 R7 R8 status after read", v, {T1, 1'b1, 3'b100, 4'b0100, 3'b000});
    for (int k = 0; k < 4; k++) begin
      wreg(2'd2, ctl(1'b0, 2'b00, 0, k, 2'b00));
      rreg(2'd0, v);
      check("R2 R3 read buffer dword", v, dw[k]);
    end
  endtask

  task automatic t_ext_view;
    logic [31:0] v;
    wreg(2'd1, {T2, 1'b0, 10'h0});
    wreg(2'd2, ctl(1'b0, 2'b11, 5, 1, 2'b01));   // shared, way 1
    wreg(2'd2, ctl(1'b1, 2'b01, 5, 1, 2'b10));
    rreg(2'd2, v);
    check("R5 control readback", v, ctl(1'b1, 2'b01, 5, 1, 2'b10));
    rreg(2'd1, v);
    check("R6 extended status", v,
          {1'b0, 2'b11, 1'b0, 8'b00_10_11_00, 9'h0, 1'b1, 3'b101, 4'b0110, 3'b000});
    wreg(2'd2, ctl(1'b0, 2'b00, 5, 1, 2'b00));
    rreg(2'd1, v);
    check("R6 tag view restored", v, {T2, 1'b1, 3'b101, 4'b0110, 3'b000});
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wreg(2'd1, 32'hFFFF_FFFF);
    rreg(2'd1, v);
    check("R9 status write ignores 9:3", v, {22'h3FFFFF, 3'b101, 4'b0110, 3'b000});
    wreg(2'd2, ctl(1'b1, 2'b00, 5, 1, 2'b00));
    wreg(2'd1, 32'h0000_0000);
    wreg(2'd2, ctl(1'b0, 2'b00, 5, 1, 2'b00));
    rreg(2'd1, v);
    check("R9 tag kept under extended view", v, {21'h1FFFFF, 1'b0, 3'b101, 4'b0110, 3'b000});
  endtask

  task automatic t_flush;
    logic [31:0] v;
    wreg(2'd2, ctl(1'b0, 2'b00, 0, 0, 2'b11));
    wreg(2'd2, ctl(1'b0, 2'b00, 5, 2, 2'b10));
    rreg(2'd1, v);
    check("R10 flush clears state and lru", {21'h0, v[10:0]}, 32'h0);
  endtask

  task automatic t_write_through;
    logic [31:0] v;
    do_reset(1'b0);
    wreg(2'd2, ctl(1'b1, 2'b11, 0, 0, 2'b00));
    rreg(2'd2, v);
    check("R4 R11 ext and set state locked", v, 32'h0);
    wreg(2'd1, {T3, 1'b1, 10'h0});
    wreg(2'd2, ctl(1'b0, 2'b00, 9, 0, 2'b01));
    wreg(2'd2, ctl(1'b0, 2'b10, 9, 3, 2'b01));   // state field ignored
    wreg(2'd2, ctl(1'b0, 2'b00, 9, 3, 2'b10));
    rreg(2'd1, v);
    check("R4 R8 valid from bit10", v, {T3, 1'b1, 3'b010, 4'b1001, 3'b000});
    wreg(2'd1, {T3, 1'b0, 10'h0});
    wreg(2'd2, ctl(1'b0, 2'b11, 9, 3, 2'b01));
    wreg(2'd2, ctl(1'b0, 2'b00, 9, 3, 2'b10));
    rreg(2'd1, v);
    check("R4 R7 invalidate via bit10", v, {T3, 1'b0, 3'b010, 4'b0001, 3'b000});
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset(1'b1);
    t_reset();
    t_write_read_wb();
    t_ext_view();
    t_readonly();
    t_flush();
    t_write_through();
    finish_run();
  end
endmodule